// File: doc/BRIEF.md
# Width-Selectable Condition Code Generator

This block turns a 36-bit data-path result into the eight status flags of a processor's condition code byte. The result is viewed as a 4-bit extension, a 16-bit high portion and a 16-bit low portion. A per-operation class tells the block which flags to rewrite and at which width: 16, 32 or 36 bits, or a width chosen by a mode input. Other classes force some flags to zero or leave the byte as it is. The adder supplies the carry and two overflow indications: one at 36 bits and one at 32 bits.

The mode input (`narrow_mode`) selects how the destination-sized classes read the result. With the mode at 0 the whole 36 bits are valid. With the mode at 1 the extension is ignored and the result is read as a 32-bit value, which makes unsigned comparisons valid. The flag byte is registered and changes one clock after a valid operation. Two of its flags, the limit flag and the size flag, are sticky and clear only on reset.

Top module: `ccgen_top`

## Requirements
- R1: On a clock edge with `rst_n` low, `status` becomes 0. After a clock edge where `op_valid` is 1, `status` shows the new flags. A clock edge with `op_valid` at 0 leaves `status` unchanged.
- R2: The status bit positions are: C=0, V=1, Z=2, N=3, U=4, E=5, L=6, SZ=7. Class codes are: HOLD=0, LOGIC16=1, WIDE32=2, ARITH=3, MULT=4, TEST=5, WTEST=6, FULL36=7. The HOLD class leaves every flag unchanged, except that L can still be set by `limit_in`.
- R3: ARITH with `narrow_mode`=0 sets N from bit 35, sets Z only when all 36 bits are zero, sets V from `ovf36_in` and sets C from `carry_in`.
- R4: ARITH with `narrow_mode`=1 sets N from bit 31, sets Z when bits 31..0 are zero whatever the extension holds, and sets V from `ovf32_in`.
- R5: ARITH, MULT, TEST and FULL36 set E when bits 35..31 are not all equal, and clear it otherwise.
- R6: ARITH, MULT, TEST and FULL36 set U when bit 31 equals bit 30, and clear it otherwise.
- R7: LOGIC16 sets N from bit 15, sets Z when bits 15..0 are zero and clears V. It leaves C, E and U unchanged.
- R8: WIDE32 sets N from bit 31 and Z from bits 31..0. It leaves E, U, V and C unchanged.
- R9: TEST clears both V and C. MULT clears V and leaves C unchanged. Both take N and Z at the width chosen by `narrow_mode`.
- R10: WTEST sets N from bit 15 and Z from bits 15..0, and clears V and C. The result is the same for either value of `narrow_mode`.
- R11: FULL36 always uses the 36-bit reading: N from bit 35, Z over all 36 bits, V from `ovf36_in` and C from `carry_in`, whatever `narrow_mode` is.
- R12: L is sticky. It is set by a valid operation that has `limit_in`=1, or by an ARITH or FULL36 operation whose new V is 1. Once set, it stays set until reset.
- R13: SZ is sticky. It is set by a valid ARITH, MULT, TEST or FULL36 operation whose bits 30 and 29 differ. Once set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_class | input | 3 | Flag evaluation class (codes in R2) |
| narrow_mode | input | 1 | 1: read the result as 32 bits, ignoring the extension |
| result | input | 36 | Result: extension [35:32], high [31:16], low [15:0] |
| carry_in | input | 1 | Carry out of the adder |
| ovf36_in | input | 1 | Overflow out of the adder at 36 bits |
| ovf32_in | input | 1 | Overflow out of the adder at 32 bits |
| limit_in | input | 1 | Limiting occurred on an accumulator read |
| status | output | 8 | Registered status byte |

## Verification
Some results are zero only in the low 32 bits, with a non-zero extension. These are applied to ARITH, TEST, WIDE32 and FULL36 under both mode values, which shows whether Z and N follow the selected width or a fixed one. Sign patterns across bits 35..29 separate the extension check E from the normalization check U and the growth check that sets SZ. Sequences of LOGIC16 and HOLD operations after C and L have been set show which flags each class must leave untouched. A stream of pseudo-random operations mixes all classes and both modes. A reset in the middle of the run shows that the sticky flags clear.

// File: rtl/ccgen_pkg.sv
// Package: shared class encoding and status-byte bit positions for the
// condition code generator. Assumes an 8-bit status byte.
package ccgen_pkg;

    typedef enum logic [2:0] {
        CLS_HOLD    = 3'd0,
        CLS_LOGIC16 = 3'd1,
        CLS_WIDE32  = 3'd2,
        CLS_ARITH   = 3'd3,
        CLS_MULT    = 3'd4,
        CLS_TEST    = 3'd5,
        CLS_WTEST   = 3'd6,
        CLS_FULL36  = 3'd7
    } op_class_e;

    localparam int FLAG_W = 8;
    localparam int FB_C   = 0;
    localparam int FB_V   = 1;
    localparam int FB_Z   = 2;
    localparam int FB_N   = 3;
    localparam int FB_U   = 4;
    localparam int FB_E   = 5;
    localparam int FB_L   = 6;
    localparam int FB_SZ  = 7;

    // index of each width evaluator
    localparam int WI_16 = 0;
    localparam int WI_32 = 1;
    localparam int WI_36 = 2;
    localparam int N_WIDTHS = 3;

endpackage

// File: rtl/ccgen_width_eval.sv
// Width evaluator: sign and zero test of the low SPAN bits of a result.
// Assumes SPAN <= RES_W. Purely combinational.
module ccgen_width_eval #(
    parameter int RES_W = 36,
    parameter int SPAN  = 32
) (
    input  logic [RES_W-1:0] res,
    output logic             sign,
    output logic             zero
);
    // take the top bit of the span as sign, reduce the span for zero
    always_comb begin
        sign = res[SPAN-1];
        zero = ~|res[SPAN-1:0];
    end
endmodule

// File: rtl/ccgen_range_flags.sv
// Range evaluator: extension-in-use (E), unnormalized (U) and growth
// (SZ condition) tests. Assumes a result of EXT_W extension bits above two
// PORT_W portions. Combinational.
module ccgen_range_flags #(
    parameter int EXT_W  = 4,
    parameter int PORT_W = 16
) (
    input  logic [EXT_W+2*PORT_W-1:0] res,
    output logic                      ext_used,
    output logic                      unnorm,
    output logic                      growth
);
    localparam int RES_W = EXT_W + 2 * PORT_W;
    localparam int MSB32 = 2 * PORT_W - 1;

    logic [RES_W-1-MSB32:0] top_bits;

    // E: extension plus bit 31 not a pure sign run; U and growth from bits 31..29
    always_comb begin
        top_bits = res[RES_W-1:MSB32];
        ext_used = (|top_bits) && !(&top_bits);
        unnorm   = (res[MSB32] == res[MSB32-1]);
        growth   = res[MSB32-1] ^ res[MSB32-2];
    end
endmodule

// File: rtl/ccgen_flag_merge.sv
// Flag merger: builds the next status byte from the current byte, the
// width evaluations and the operation class. Assumes evaluator index order
// 16/32/36 as in ccgen_pkg. Combinational.
module ccgen_flag_merge
    import ccgen_pkg::*;
(
    input  logic              op_valid,
    input  op_class_e         op_class,
    input  logic              narrow_mode,
    input  logic [FLAG_W-1:0] cur,
    input  logic [N_WIDTHS-1:0] w_sign,
    input  logic [N_WIDTHS-1:0] w_zero,
    input  logic              ext_used,
    input  logic              unnorm,
    input  logic              growth,
    input  logic              carry_in,
    input  logic              ovf36_in,
    input  logic              ovf32_in,
    input  logic              limit_in,
    output logic [FLAG_W-1:0] nxt
);
    logic sel_n;
    logic sel_z;
    logic sel_v;
    logic ovf_class;
    logic grow_class;

    // width chosen by the mode for destination-sized classes
    always_comb begin
        sel_n = narrow_mode ? w_sign[WI_32] : w_sign[WI_36];
        sel_z = narrow_mode ? w_zero[WI_32] : w_zero[WI_36];
        sel_v = narrow_mode ? ovf32_in : ovf36_in;
    end

    // per-class flag update, then the sticky limit and size flags
    always_comb begin
        nxt        = cur;
        ovf_class  = 1'b0;
        grow_class = 1'b0;
        if (op_valid) begin
            unique case (op_class)
                CLS_HOLD: begin
                end
                CLS_LOGIC16: begin
                    nxt[FB_N] = w_sign[WI_16];
                    nxt[FB_Z] = w_zero[WI_16];
                    nxt[FB_V] = 1'b0;
                end
                CLS_WIDE32: begin
                    nxt[FB_N] = w_sign[WI_32];
                    nxt[FB_Z] = w_zero[WI_32];
                end
                CLS_ARITH: begin
                    nxt[FB_E]  = ext_used;
                    nxt[FB_U]  = unnorm;
                    nxt[FB_N]  = sel_n;
                    nxt[FB_Z]  = sel_z;
                    nxt[FB_V]  = sel_v;
                    nxt[FB_C]  = carry_in;
                    ovf_class  = 1'b1;
                    grow_class = 1'b1;
                end
                CLS_MULT: begin
                    nxt[FB_E]  = ext_used;
                    nxt[FB_U]  = unnorm;
                    nxt[FB_N]  = sel_n;
                    nxt[FB_Z]  = sel_z;
                    nxt[FB_V]  = 1'b0;
                    grow_class = 1'b1;
                end
                CLS_TEST: begin
                    nxt[FB_E]  = ext_used;
                    nxt[FB_U]  = unnorm;
                    nxt[FB_N]  = sel_n;
                    nxt[FB_Z]  = sel_z;
                    nxt[FB_V]  = 1'b0;
                    nxt[FB_C]  = 1'b0;
                    grow_class = 1'b1;
                end
                CLS_WTEST: begin
                    nxt[FB_N] = w_sign[WI_16];
                    nxt[FB_Z] = w_zero[WI_16];
                    nxt[FB_V] = 1'b0;
                    nxt[FB_C] = 1'b0;
                end
                CLS_FULL36: begin
                    nxt[FB_E]  = ext_used;
                    nxt[FB_U]  = unnorm;
                    nxt[FB_N]  = w_sign[WI_36];
                    nxt[FB_Z]  = w_zero[WI_36];
                    nxt[FB_V]  = ovf36_in;
                    nxt[FB_C]  = carry_in;
                    ovf_class  = 1'b1;
                    grow_class = 1'b1;
                end
                default: begin
                end
            endcase
            nxt[FB_L]  = cur[FB_L] | limit_in | (ovf_class & nxt[FB_V]);
            nxt[FB_SZ] = cur[FB_SZ] | (grow_class & growth);
        end
    end
endmodule

// File: rtl/ccgen_top.sv
// Condition code generator top: evaluates a result at 16, 32 and 36 bits,
// merges the flags by class and mode, and registers the status byte.
// Assumes one operation per cycle and a synchronous active-low reset.
module ccgen_top
    import ccgen_pkg::*;
#(
    parameter int EXT_W  = 4,
    parameter int PORT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          op_valid,
    input  logic [2:0]                    op_class,
    input  logic                          narrow_mode,
    input  logic [EXT_W+2*PORT_W-1:0]     result,
    input  logic                          carry_in,
    input  logic                          ovf36_in,
    input  logic                          ovf32_in,
    input  logic                          limit_in,
    output logic [FLAG_W-1:0]             status
);
    localparam int RES_W = EXT_W + 2 * PORT_W;
    localparam int MSB32 = 2 * PORT_W - 1;

    function automatic int span_of(input int idx);
        return (idx == WI_16) ? PORT_W : (idx == WI_32) ? 2 * PORT_W : RES_W;
    endfunction

    logic [N_WIDTHS-1:0] w_sign;
    logic [N_WIDTHS-1:0] w_zero;
    logic                ext_used;
    logic                unnorm;
    logic                growth;
    logic [FLAG_W-1:0]   status_d;
    op_class_e           cls;

    // map the raw class code to the enum
    always_comb cls = op_class_e'(op_class);

    for (genvar gi = 0; gi < N_WIDTHS; gi++) begin : g_width
        ccgen_width_eval #(
            .RES_W (RES_W),
            .SPAN  (span_of(gi))
        ) i_eval (
            .res  (result),
            .sign (w_sign[gi]),
            .zero (w_zero[gi])
        );
    end

    ccgen_range_flags #(
        .EXT_W  (EXT_W),
        .PORT_W (PORT_W)
    ) i_range (
        .res      (result),
        .ext_used (ext_used),
        .unnorm   (unnorm),
        .growth   (growth)
    );

    ccgen_flag_merge i_merge (
        .op_valid    (op_valid),
        .op_class    (cls),
        .narrow_mode (narrow_mode),
        .cur         (status),
        .w_sign      (w_sign),
        .w_zero      (w_zero),
        .ext_used    (ext_used),
        .unnorm      (unnorm),
        .growth      (growth),
        .carry_in    (carry_in),
        .ovf36_in    (ovf36_in),
        .ovf32_in    (ovf32_in),
        .limit_in    (limit_in),
        .nxt         (status_d)
    );

    // status register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= status_d;
    end

    // R1: reset clears the byte
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> status == '0);

    // R2: hold class with no limiting keeps the byte
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_class == CLS_HOLD && !limit_in |=> $stable(status));

    // R4: narrow mode zero looks only at the low 32 bits
    a_r4_narrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_class == CLS_ARITH && narrow_mode && result[MSB32:0] == '0
        |=> status[FB_Z]);

    // R5: a pure sign run in bits 35..31 clears E
    a_r5_ext_clear: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_class == CLS_FULL36 && (&result[RES_W-1:MSB32])
        |=> !status[FB_E]);

    // R7: logic class leaves carry and clears V
    a_r7_logic_carry: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_class == CLS_LOGIC16
        |=> status[FB_C] == $past(status[FB_C]) && !status[FB_V]);

    // R9: test class clears V and C
    a_r9_test_clear: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_class == CLS_TEST |=> !status[FB_V] && !status[FB_C]);

    // R11: full-width class never reports zero with a non-zero extension
    a_r11_full_zero: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_class == CLS_FULL36 && result[RES_W-1:2*PORT_W] != '0
        |=> !status[FB_Z]);

    // R12: limit flag is sticky
    a_r12_limit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        status[FB_L] |=> status[FB_L]);

    // R13: size flag is sticky
    a_r13_size_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        status[FB_SZ] |=> status[FB_SZ]);

endmodule

// File: tb/test_ccgen_top.sv
module test_ccgen_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_class = 3'd0;
    logic        narrow_mode = 1'b0;
    logic [35:0] result = '0;
    logic        carry_in = 1'b0;
    logic        ovf36_in = 1'b0;
    logic        ovf32_in = 1'b0;
    logic        limit_in = 1'b0;
    logic [7:0]  status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] mstate = '0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;  // 125 MHz

    ccgen_top i_ccgen_top (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .narrow_mode(narrow_mode), .result(result), .carry_in(carry_in),
        .ovf36_in(ovf36_in), .ovf32_in(ovf32_in), .limit_in(limit_in),
        .status(status)
    );

    // reference model written from the requirements (bit order R2)
    function automatic logic [7:0] model(input logic [7:0] cur, input bit vld,
        input logic [2:0] cls, input bit md, input logic [35:0] r,
        input bit c, input bit v36, input bit v32, input bit lim);
        logic [7:0] s = cur;
        bit e_f = !(r[35:31] == 5'b00000 || r[35:31] == 5'b11111);
        bit u_f = (r[31] == r[30]);
        bit n_sel = md ? r[31] : r[35];
        bit z_sel = md ? (r[31:0] == 0) : (r == 0);
        bit sets_v = 0;
        bit grows = 0;
        if (!vld) return cur;
        case (cls)
            3'd1: begin s[3] = r[15]; s[2] = (r[15:0] == 0); s[1] = 0; end
            3'd2: begin s[3] = r[31]; s[2] = (r[31:0] == 0); end
            3'd3: begin s[5] = e_f; s[4] = u_f; s[3] = n_sel; s[2] = z_sel;
                        s[1] = md ? v32 : v36; s[0] = c; sets_v = 1; grows = 1; end
            3'd4: begin s[5] = e_f; s[4] = u_f; s[3] = n_sel; s[2] = z_sel;
                        s[1] = 0; grows = 1; end
            3'd5: begin s[5] = e_f; s[4] = u_f; s[3] = n_sel; s[2] = z_sel;
                        s[1] = 0; s[0] = 0; grows = 1; end
            3'd6: begin s[3] = r[15]; s[2] = (r[15:0] == 0); s[1] = 0; s[0] = 0; end
            3'd7: begin s[5] = e_f; s[4] = u_f; s[3] = r[35]; s[2] = (r == 0);
                        s[1] = v36; s[0] = c; sets_v = 1; grows = 1; end
            default: ;
        endcase
        if (lim || (sets_v && s[1])) s[6] = 1;
        if (grows && (r[30] != r[29])) s[7] = 1;
        return s;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s status=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // driver: apply one operation and queue its expected byte
    task automatic drive(input logic [2:0] cls, input bit md, input logic [35:0] r,
        input bit c, input bit v36, input bit v32, input bit lim, input string tag);
        @(negedge clk);
        op_valid = 1; op_class = cls; narrow_mode = md; result = r;
        carry_in = c; ovf36_in = v36; ovf32_in = v32; limit_in = lim;
        mstate = model(mstate, 1, cls, md, r, c, v36, v32, lim);
        exp_q.push_back(mstate);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        op_valid = 0; op_class = 3'd3; result = 36'h0_0000_0000; limit_in = 1;
        exp_q.push_back(mstate);
        tag_q.push_back(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; op_valid = 0; limit_in = 0;
        @(posedge clk); @(negedge clk);
        check("R1 reset", status, 8'h00);
        mstate = '0;
        rst_n = 1;
    endtask

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) check(tag_q.pop_front(), status, exp_q.pop_front());
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", status, 8'h00);
        rst_n = 1;
        // R3: full width, negative with overflow -> N,V,E,U,L
        drive(3'd3, 0, 36'h8_0000_0000, 1, 1, 0, 0, "R3 arith wide");
        // R1: idle edge holds even with limit asserted
        idle("R1 idle hold");
        // R4: zero in low 32 with extension set
        drive(3'd3, 1, 36'hF_0000_0000, 0, 0, 1, 0, "R4 arith narrow");
        drive(3'd3, 0, 36'hF_0000_0000, 0, 0, 1, 0, "R3 arith wide nonzero");
        // R5 and R6 patterns
        drive(3'd3, 0, 36'hF_8000_0000, 0, 0, 0, 0, "R5 sign run");
        drive(3'd3, 0, 36'h0_8000_0000, 0, 0, 0, 0, "R5 ext used");
        drive(3'd3, 0, 36'h0_4000_0000, 0, 0, 0, 0, "R6 normalized");
        // R7: logic keeps carry set earlier
        drive(3'd3, 0, 36'h0_0000_0001, 1, 0, 0, 0, "R3 carry set");
        drive(3'd1, 0, 36'h0_0000_8000, 0, 1, 1, 0, "R7 logic16");
        drive(3'd1, 1, 36'hF_FFFF_0000, 0, 0, 0, 0, "R7 logic16 zero");
        // R8
        drive(3'd2, 0, 36'hF_0000_0000, 0, 1, 1, 0, "R8 wide32 zero");
        drive(3'd2, 1, 36'h0_8000_0001, 0, 0, 0, 0, "R8 wide32 neg");
        // R9
        drive(3'd5, 1, 36'hF_0000_0000, 1, 1, 1, 0, "R9 test narrow");
        drive(3'd3, 0, 36'h0_0000_0001, 1, 0, 0, 0, "R3 carry again");
        drive(3'd4, 0, 36'h8_0000_0000, 0, 1, 1, 0, "R9 mult keeps C");
        // R10: same input under both modes
        drive(3'd6, 0, 36'hF_0000_8000, 1, 1, 1, 0, "R10 wtest mode0");
        drive(3'd6, 1, 36'hF_0000_8000, 1, 1, 1, 0, "R10 wtest mode1");
        // R11
        drive(3'd7, 1, 36'h1_0000_0000, 1, 0, 1, 0, "R11 full36 narrow");
        // R2: hold class, then hold with limit
        do_reset();
        drive(3'd0, 1, 36'h0_0000_0000, 1, 1, 1, 0, "R2 hold");
        drive(3'd0, 0, 36'h0_0000_0000, 1, 1, 1, 1, "R2 hold limit");
        drive(3'd1, 0, 36'h0_0000_0001, 0, 0, 0, 0, "R12 L sticky");
        // R13
        drive(3'd4, 0, 36'h0_4000_0000, 0, 0, 0, 0, "R13 growth");
        drive(3'd6, 0, 36'h0_0000_0000, 0, 0, 0, 0, "R13 SZ sticky");
        do_reset();
        drive(3'd1, 0, 36'h0_6000_0000, 0, 0, 0, 0, "R13 logic no growth");
        drive(3'd3, 1, 36'h0_0000_0001, 0, 1, 0, 0, "R12 narrow no ovf");
        // mixed stream
        for (int k = 0; k < 60; k++) begin
            logic [35:0] rv;
            rv = {$urandom(), $urandom()};
            if (k % 5 == 0) rv[31:0] = '0;
            drive(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), rv,
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), (k % 17 == 16), "R2 mixed");
        end
        idle("R1 idle end");
        repeat (4) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule